// File: doc/BRIEF.md
# Whole-Polynomial Arithmetic Engine

This block is a small engine in which every register is a complete polynomial of N coefficients modulo a prime Q, with Q ≡ 1 mod 2N. A single command names a destination register and up to two source registers. The command then runs over every coefficient before the next one is taken. The commands are forward NTT, inverse NTT, point-wise product, sum, difference, copy, and a fill from an external small-noise sampler. Together they are enough to write key generation, encryption and decryption for ring-based lattice schemes as short command lists on one core. To multiply two polynomials, software transforms both into the NTT domain, takes their point-wise product and transforms the result back. The result is the negacyclic product modulo x^N + 1.

The polynomials live in an internal RAM with two read ports and two write ports. One modular datapath serves the element-wise commands and the butterflies, and it shares a single multiplier between them. The twiddle constants are computed while the design is elaborated, from N and Q alone. An external word port loads and reads back individual coefficients while the engine is idle.

Top module: `polyproc`

## Requirements
- R1: After reset `busy` and `smp_rd` are low.
- R2: Command code 3 (sum) writes (a+b) mod Q into the destination for every coefficient, with the result in [0, Q) even when both inputs are Q-1.
- R3: Command code 4 (difference) writes a-b, adding Q when the difference is negative, so 0-(Q-1) gives 1.
- R4: Command code 2 (point-wise product) writes (a·b) mod Q into each coefficient position.
- R5: Command code 5 copies source A into the destination. Command code 6 fills the destination with N successive signed sampler values, one per cycle, mapping a negative value v to Q+v. `smp_rd` is high in each cycle that takes a value.
- R6: Command code 0 (forward NTT) followed by command code 1 (inverse NTT) on the same register returns the original polynomial. The inverse includes the scaling by N^-1 mod Q.
- R7: The forward NTT of both operands, then the point-wise product, then the inverse NTT yields the negacyclic product modulo x^N + 1.
- R8: `busy` rises in the cycle after a command is accepted. It stays high for N cycles for codes 2 to 6, for (N/2)·log2(N) cycles for code 0 and for (N/2)·log2(N)+N cycles for code 1.
- R9: A command offered while `busy` is high has no effect, and an external write offered while `busy` is high does not change the register file.
- R10: Command code 7 is reserved. It leaves `busy` low and changes no register.
- R11: While idle, `ext_we` writes `ext_wdata` into coefficient `ext_idx` of register `ext_reg` at the clock edge, and `ext_rdata` shows that coefficient combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Command offered this cycle |
| op_code | input | 3 | Command code (0 fwd NTT, 1 inv NTT, 2 product, 3 sum, 4 difference, 5 copy, 6 sample fill, 7 reserved) |
| op_dst | input | log2(NREG) | Destination register; also the operand of both transforms |
| op_src_a | input | log2(NREG) | First source register |
| op_src_b | input | log2(NREG) | Second source register |
| busy | output | 1 | Command in progress |
| smp_val | input | SW | Signed sampler value taken when smp_rd is high |
| smp_rd | output | 1 | Sampler value consumed at this clock edge |
| ext_we | input | 1 | External coefficient write (idle only) |
| ext_reg | input | log2(NREG) | External access register |
| ext_idx | input | log2(N) | External access coefficient index |
| ext_wdata | input | ceil(log2(Q)) | External write data, below Q |
| ext_rdata | output | ceil(log2(Q)) | Coefficient at ext_reg/ext_idx |

## Verification
The transform pair is driven with an arithmetic ramp, with an all-(Q-1) polynomial and with a single unit coefficient. The ramp exposes wrong butterfly addressing, the all-(Q-1) input exposes missing reductions, and the unit impulse exposes a wrong twiddle or scale. Products are checked against a schoolbook negacyclic model for a ramp against a quadratic sequence, for x·x^(N-1), where only the wrap sign gives the expected -1, and for all-(Q-1) operands. The element-wise commands use operand pairs placed at the 0 and Q-1 edges, so that a missing subtract or add of Q shows up. Cycle counts of `busy` separate the transform lengths from the element-wise length.

// File: rtl/polyproc_pkg.sv
package polyproc_pkg;

  typedef enum logic [2:0] {
    OP_NTT  = 3'd0,
    OP_INTT = 3'd1,
    OP_PMUL = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_MOV  = 3'd5,
    OP_SMP  = 3'd6,
    OP_RSV  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    AL_PASS,
    AL_ADD,
    AL_SUB,
    AL_MUL,
    AL_BFF,
    AL_BFI
  } alu_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ELEM,
    ST_BFLY,
    ST_SCALE
  } st_e;

  // modular exponentiation by squaring, used only at elaboration
  function automatic longint unsigned pow_mod(longint unsigned b, longint unsigned e,
                                              longint unsigned m);
    longint unsigned r;
    longint unsigned x;
    longint unsigned k;
    r = 1;
    x = b % m;
    k = e;
    while (k != 0) begin
      if ((k & 64'd1) != 0) r = (r * x) % m;
      x = (x * x) % m;
      k = k >> 1;
    end
    return r;
  endfunction

  // first element whose order is exactly 2n (psi^n == -1)
  function automatic longint unsigned find_psi(longint unsigned n, longint unsigned q);
    longint unsigned res;
    longint unsigned cand;
    res = 0;
    for (longint unsigned g = 2; g < q; g++) begin
      if (res == 0) begin
        cand = pow_mod(g, (q - 1) / (2 * n), q);
        if (pow_mod(cand, n, q) == q - 1) res = cand;
      end
    end
    return res;
  endfunction

  function automatic longint unsigned bit_rev(longint unsigned v, longint unsigned bits);
    longint unsigned r;
    r = 0;
    for (longint unsigned i = 0; i < bits; i++)
      if (((v >> i) & 64'd1) != 0) r = r | (64'd1 << (bits - 1 - i));
    return r;
  endfunction

endpackage

// File: rtl/polyproc_twiddle.sv
module polyproc_twiddle
  import polyproc_pkg::*;
#(
  parameter int unsigned N    = 16,
  parameter int unsigned Q    = 97,
  parameter int unsigned LOGN = 4,
  parameter int unsigned QW   = 7
) (
  input  logic [LOGN-1:0] idx,
  input  logic            inv,
  output logic [QW-1:0]   w,
  output logic [QW-1:0]   n_inv
);

  localparam longint unsigned PSI  = find_psi(64'(N), 64'(Q));
  localparam longint unsigned NINV = pow_mod(64'(N), 64'(Q) - 64'd2, 64'(Q));

  logic [QW-1:0] fwd_rom [N];
  logic [QW-1:0] inv_rom [N];

  // bit-reversed powers of psi and of psi^-1 (= psi^(2N-e))
  for (genvar k = 0; k < N; k++) begin : g_rom
    localparam longint unsigned E  = bit_rev(64'(k), 64'(LOGN));
    localparam longint unsigned WF = pow_mod(PSI, E, 64'(Q));
    localparam longint unsigned WI = pow_mod(PSI, 64'(2 * N) - E, 64'(Q));
    assign fwd_rom[k] = QW'(WF);
    assign inv_rom[k] = QW'(WI);
  end

  assign w     = inv ? inv_rom[idx] : fwd_rom[idx];
  assign n_inv = QW'(NINV);

endmodule

// File: rtl/polyproc_alu.sv
module polyproc_alu
  import polyproc_pkg::*;
#(
  parameter int unsigned Q  = 97,
  parameter int unsigned QW = 7
) (
  input  alu_e          mode,
  input  logic [QW-1:0] x,
  input  logic [QW-1:0] y,
  input  logic [QW-1:0] w,
  output logic [QW-1:0] r0,
  output logic [QW-1:0] r1
);

  localparam int unsigned PW = 2 * QW;
  localparam logic [QW:0]   QE = (QW+1)'(Q);
  localparam logic [PW-1:0] QP = PW'(Q);

  function automatic logic [QW-1:0] add_q(logic [QW-1:0] a, logic [QW-1:0] b);
    logic [QW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= QE) s = s - QE;
    return s[QW-1:0];
  endfunction

  function automatic logic [QW-1:0] sub_q(logic [QW-1:0] a, logic [QW-1:0] b);
    logic [QW:0] d;
    d = {1'b0, a} - {1'b0, b};
    if (d[QW]) d = d + QE;
    return d[QW-1:0];
  endfunction

  logic [QW-1:0] diff, ma, mb, mres;
  logic [PW-1:0] prod;

  always_comb begin
    diff = sub_q(x, y);
    ma   = x;
    mb   = w;
    case (mode)
      AL_BFF:  ma = y;
      AL_BFI:  ma = diff;
      AL_MUL:  mb = y;
      default: ;
    endcase
    // one shared multiplier with reduction by the constant modulus
    prod = {{QW{1'b0}}, ma} * {{QW{1'b0}}, mb};
    mres = QW'(prod % QP);
    r0   = x;
    r1   = y;
    case (mode)
      AL_ADD: r0 = add_q(x, y);
      AL_SUB: r0 = diff;
      AL_MUL: r0 = mres;
      AL_BFF: begin
        r0 = add_q(x, mres);
        r1 = sub_q(x, mres);
      end
      AL_BFI: begin
        r0 = add_q(x, y);
        r1 = mres;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/polyproc_seq.sv
module polyproc_seq
  import polyproc_pkg::*;
#(
  parameter int unsigned LOGN = 4,
  parameter int unsigned RW   = 2,
  parameter int unsigned LW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [2:0]           op_code,
  input  logic [RW-1:0]        op_dst,
  input  logic [RW-1:0]        op_src_a,
  input  logic [RW-1:0]        op_src_b,
  output logic                 busy,
  output logic                 smp_rd,
  output logic [RW+LOGN-1:0]   ra_addr,
  output logic [RW+LOGN-1:0]   rb_addr,
  output logic [RW+LOGN-1:0]   wa0,
  output logic [RW+LOGN-1:0]   wa1,
  output logic                 we0,
  output logic                 we1,
  output alu_e                 alu_mode,
  output logic [LOGN-1:0]      tw_idx,
  output logic                 tw_inv,
  output logic                 use_ninv,
  output logic                 sel_smp
);

  localparam logic [LOGN-1:0] IDX_LAST = '1;
  localparam logic [LW-1:0]   LT_TOP   = LW'(LOGN - 1);

  st_e             st_q, st_d;
  op_e             op_q, op_d;
  logic [RW-1:0]   dst_q, dst_d, sa_q, sa_d, sb_q, sb_d;
  logic [LOGN-1:0] idx_q, idx_d;
  logic [LW-1:0]   lt_q, lt_d;
  logic            start, adv, b_last;
  logic [LOGN-1:0] bx, lo_mask, j_lo, j_hi, tw_base;

  assign start  = (st_q == ST_IDLE) && op_valid && (op_code != OP_RSV);
  assign busy   = (st_q != ST_IDLE);
  assign adv    = start || busy;
  assign b_last = &idx_q[LOGN-2:0];
  assign bx     = {1'b0, idx_q[LOGN-2:0]};

  // butterfly pair and twiddle index; lt_q is log2 of the pair distance
  always_comb begin
    lo_mask = (LOGN'(1) << lt_q) - LOGN'(1);
    j_lo    = (((bx >> lt_q) << lt_q) << 1) | (bx & lo_mask);
    j_hi    = j_lo | (LOGN'(1) << lt_q);
    tw_base = LOGN'(1) << (LT_TOP - lt_q);
    tw_idx  = tw_base + (bx >> lt_q);
  end

  // next state
  always_comb begin
    st_d  = st_q;
    op_d  = op_q;
    dst_d = dst_q;
    sa_d  = sa_q;
    sb_d  = sb_q;
    idx_d = idx_q;
    lt_d  = lt_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          op_d  = op_e'(op_code);
          dst_d = op_dst;
          sa_d  = op_src_a;
          sb_d  = op_src_b;
          idx_d = '0;
          if (op_code == OP_NTT) begin
            st_d = ST_BFLY;
            lt_d = LT_TOP;
          end else if (op_code == OP_INTT) begin
            st_d = ST_BFLY;
            lt_d = '0;
          end else begin
            st_d = ST_ELEM;
          end
        end
      end
      ST_ELEM, ST_SCALE: begin
        idx_d = idx_q + LOGN'(1);
        if (idx_q == IDX_LAST) st_d = ST_IDLE;
      end
      ST_BFLY: begin
        if (b_last) begin
          idx_d = '0;
          if (op_q == OP_NTT) begin
            if (lt_q == '0) st_d = ST_IDLE;
            else            lt_d = lt_q - LW'(1);
          end else begin
            if (lt_q == LT_TOP) st_d = ST_SCALE;
            else                lt_d = lt_q + LW'(1);
          end
        end else begin
          idx_d = idx_q + LOGN'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // datapath steering
  always_comb begin
    ra_addr  = {sa_q, idx_q};
    rb_addr  = {sb_q, idx_q};
    wa0      = {dst_q, idx_q};
    wa1      = {dst_q, j_hi};
    we0      = 1'b0;
    we1      = 1'b0;
    alu_mode = AL_PASS;
    tw_inv   = (op_q == OP_INTT);
    use_ninv = 1'b0;
    sel_smp  = 1'b0;
    case (st_q)
      ST_ELEM: begin
        we0     = 1'b1;
        sel_smp = (op_q == OP_SMP);
        case (op_q)
          OP_ADD:  alu_mode = AL_ADD;
          OP_SUB:  alu_mode = AL_SUB;
          OP_PMUL: alu_mode = AL_MUL;
          default: alu_mode = AL_PASS;
        endcase
      end
      ST_SCALE: begin
        ra_addr  = {dst_q, idx_q};
        use_ninv = 1'b1;
        alu_mode = AL_MUL;
        we0      = 1'b1;
      end
      ST_BFLY: begin
        ra_addr = {dst_q, j_lo};
        rb_addr = {dst_q, j_hi};
        wa0     = {dst_q, j_lo};
        we0     = 1'b1;
        we1     = 1'b1;
        if (op_q == OP_NTT) alu_mode = AL_BFF;
        else                alu_mode = AL_BFI;
      end
      default: ;
    endcase
    smp_rd = sel_smp;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_MOV;
      dst_q <= '0;
      sa_q  <= '0;
      sb_q  <= '0;
      idx_q <= '0;
      lt_q  <= '0;
    end else if (adv) begin
      st_q  <= st_d;
      op_q  <= op_d;
      dst_q <= dst_d;
      sa_q  <= sa_d;
      sb_q  <= sb_d;
      idx_q <= idx_d;
      lt_q  <= lt_d;
    end
  end

  // R9: a command offered mid-run leaves the latched command untouched
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_valid) |=> ($stable(op_q) && $stable(dst_q) && $stable(sa_q) && $stable(sb_q)));

  // R10: the reserved code never starts a run
  a_r10_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && op_valid && op_code == 3'd7) |=> !busy);

  // R8: an accepted command raises busy on the next cycle
  a_r8_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && op_valid && op_code != 3'd7) |=> busy);

  // R8: a forward transform only finishes after its distance-1 stage
  a_r8_ntt_last_stage: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && op_q == OP_NTT) |-> ($past(lt_q) == '0));

endmodule

// File: rtl/polyproc.sv
module polyproc
  import polyproc_pkg::*;
#(
  parameter int unsigned N    = 16,
  parameter int unsigned Q    = 97,
  parameter int unsigned NREG = 4,
  parameter int unsigned SW   = 4,
  localparam int unsigned LOGN = $clog2(N),
  localparam int unsigned QW   = $clog2(Q),
  localparam int unsigned RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [2:0]           op_code,
  input  logic [RW-1:0]        op_dst,
  input  logic [RW-1:0]        op_src_a,
  input  logic [RW-1:0]        op_src_b,
  output logic                 busy,
  input  logic signed [SW-1:0] smp_val,
  output logic                 smp_rd,
  input  logic                 ext_we,
  input  logic [RW-1:0]        ext_reg,
  input  logic [LOGN-1:0]      ext_idx,
  input  logic [QW-1:0]        ext_wdata,
  output logic [QW-1:0]        ext_rdata
);

  localparam int unsigned AW    = RW + LOGN;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned LW    = (LOGN > 2) ? $clog2(LOGN) : 1;

  logic [1:0]    rst_pipe;
  logic          rst_ni;
  logic [AW-1:0] ra_addr, rb_addr, wa0, wa1;
  logic          we0, we1, tw_inv, use_ninv, sel_smp;
  alu_e          alu_mode;
  logic [LOGN-1:0] tw_idx;
  logic [QW-1:0] ra_data, rb_data, tw_w, n_inv, y_in, r0, r1, wd0, smp_coef;
  logic [QW:0]   smp_ext;
  logic          ext_wr;

  logic [QW-1:0] ram [DEPTH];

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  polyproc_seq #(.LOGN(LOGN), .RW(RW), .LW(LW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_dst   (op_dst),
    .op_src_a (op_src_a),
    .op_src_b (op_src_b),
    .busy     (busy),
    .smp_rd   (smp_rd),
    .ra_addr  (ra_addr),
    .rb_addr  (rb_addr),
    .wa0      (wa0),
    .wa1      (wa1),
    .we0      (we0),
    .we1      (we1),
    .alu_mode (alu_mode),
    .tw_idx   (tw_idx),
    .tw_inv   (tw_inv),
    .use_ninv (use_ninv),
    .sel_smp  (sel_smp)
  );

  polyproc_twiddle #(.N(N), .Q(Q), .LOGN(LOGN), .QW(QW)) u_tw (
    .idx   (tw_idx),
    .inv   (tw_inv),
    .w     (tw_w),
    .n_inv (n_inv)
  );

  assign ra_data = ram[ra_addr];
  assign rb_data = ram[rb_addr];
  assign y_in    = use_ninv ? n_inv : rb_data;

  polyproc_alu #(.Q(Q), .QW(QW)) u_alu (
    .mode (alu_mode),
    .x    (ra_data),
    .y    (y_in),
    .w    (tw_w),
    .r0   (r0),
    .r1   (r1)
  );

  // signed sample folded into [0, Q)
  always_comb begin
    smp_ext  = {{(QW + 1 - SW){smp_val[SW-1]}}, smp_val};
    smp_coef = smp_val[SW-1] ? QW'(smp_ext + (QW+1)'(Q)) : smp_ext[QW-1:0];
  end

  assign wd0       = sel_smp ? smp_coef : r0;
  assign ext_wr    = ext_we && !busy;
  assign ext_rdata = ram[{ext_reg, ext_idx}];

  always_ff @(posedge clk) begin
    if (we0)    ram[wa0] <= wd0;
    if (we1)    ram[wa1] <= r1;
    if (ext_wr) ram[{ext_reg, ext_idx}] <= ext_wdata;
  end

  // R2: every arithmetic result lands in [0, Q)
  a_r2_wdata_reduced: assert property (@(posedge clk) disable iff (!rst_ni)
    (we0 && alu_mode != AL_PASS) |-> (wd0 < QW'(Q)));

endmodule

// File: tb/polyproc_test.sv
module polyproc_test;

  localparam int N    = 16;
  localparam int Q    = 97;
  localparam int NREG = 4;
  localparam int SW   = 4;
  localparam int LOGN = 4;
  localparam int NTT_CYC = (N / 2) * LOGN;

  typedef int poly_t [N];

  logic              clk;
  logic              rst_n;
  logic              op_valid;
  logic [2:0]        op_code;
  logic [1:0]        op_dst, op_src_a, op_src_b;
  logic              busy;
  logic signed [3:0] smp_val;
  logic              smp_rd;
  logic              ext_we;
  logic [1:0]        ext_reg;
  logic [3:0]        ext_idx;
  logic [6:0]        ext_wdata;
  logic [6:0]        ext_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  polyproc #(.N(N), .Q(Q), .NREG(NREG), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_dst(op_dst), .op_src_a(op_src_a), .op_src_b(op_src_b), .busy(busy),
    .smp_val(smp_val), .smp_rd(smp_rd), .ext_we(ext_we), .ext_reg(ext_reg),
    .ext_idx(ext_idx), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int smp_f(int k);
    return ((k * 5) % 15) - 7;
  endfunction

  function automatic poly_t negmul(poly_t x, poly_t y);
    poly_t c;
    for (int i = 0; i < N; i++) c[i] = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int p;
        p = (x[i] * y[j]) % Q;
        if (i + j < N) c[i+j] = (c[i+j] + p) % Q;
        else           c[i+j-N] = (c[i+j-N] + Q - p) % Q;
      end
    return c;
  endfunction

  task automatic load(input int r, input poly_t v);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ext_we    = 1'b1;
      ext_reg   = 2'(r);
      ext_idx   = 4'(i);
      ext_wdata = 7'(v[i]);
    end
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic fetch(input int r, output poly_t v);
    ext_we = 1'b0;
    for (int i = 0; i < N; i++) begin
      ext_reg = 2'(r);
      ext_idx = 4'(i);
      #1;
      v[i] = int'(ext_rdata);
    end
  endtask

  task automatic run(input int op, input int d, input int a, input int b, output int cyc);
    int k;
    k = 0;
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = 3'(op);
    op_dst   = 2'(d);
    op_src_a = 2'(a);
    op_src_b = 2'(b);
    @(negedge clk);
    op_valid = 1'b0;
    cyc = 0;
    while (busy) begin
      if (smp_rd) begin
        smp_val = 4'(smp_f(k));
        k++;
      end
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic prod_check(input poly_t x, input poly_t y, input string tag);
    poly_t got, want;
    int c;
    want = negmul(x, y);
    load(0, x);
    load(1, y);
    run(0, 0, 0, 0, c);  chk("R8 forward transform cycles", c, NTT_CYC);
    run(0, 1, 1, 1, c);
    run(2, 2, 0, 1, c);  chk("R8 product cycles", c, N);
    run(1, 2, 2, 2, c);  chk("R8 inverse transform cycles", c, NTT_CYC + N);
    fetch(2, got);
    for (int i = 0; i < N; i++)
      chk($sformatf("R7 %s coef %0d", tag, i), got[i], want[i]);
  endtask

  task automatic ident_check(input poly_t x, input string tag);
    poly_t got;
    int c;
    load(3, x);
    run(0, 3, 0, 0, c);
    run(1, 3, 0, 0, c);
    fetch(3, got);
    for (int i = 0; i < N; i++)
      chk($sformatf("R6 %s coef %0d", tag, i), got[i], x[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    poly_t pa, pb, pm, pz, pd, px1, pxn, got;
    int c;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_dst = '0; op_src_a = '0;
    op_src_b = '0; smp_val = '0; ext_we = 1'b0; ext_reg = '0; ext_idx = '0; ext_wdata = '0;
    for (int i = 0; i < N; i++) begin
      pa[i]  = (i * 37 + 11) % Q;
      pb[i]  = (i * i * 13 + 5) % Q;
      pm[i]  = Q - 1;
      pz[i]  = 0;
      pd[i]  = (i == 0) ? 1 : 0;
      px1[i] = (i == 1) ? 1 : 0;
      pxn[i] = (i == N - 1) ? 1 : 0;
    end
    pa[0] = 0;
    pb[0] = Q - 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 smp_rd after reset", int'(smp_rd), 0);

    // R11 load and read back
    load(0, pa);
    load(1, pb);
    fetch(0, got);
    for (int i = 0; i < N; i++) chk($sformatf("R11 readback coef %0d", i), got[i], pa[i]);

    // R2 sum, including (Q-1)+(Q-1)
    run(3, 2, 0, 1, c);
    chk("R8 sum cycles", c, N);
    fetch(2, got);
    for (int i = 0; i < N; i++) chk($sformatf("R2 sum coef %0d", i), got[i], (pa[i] + pb[i]) % Q);
    load(3, pm);
    run(3, 2, 3, 3, c);
    fetch(2, got);
    for (int i = 0; i < N; i++) chk($sformatf("R2 max sum coef %0d", i), got[i], Q - 2);

    // R3 difference, coef 0 is 0-(Q-1)
    run(4, 2, 0, 1, c);
    chk("R8 difference cycles", c, N);
    fetch(2, got);
    for (int i = 0; i < N; i++)
      chk($sformatf("R3 diff coef %0d", i), got[i], (pa[i] - pb[i] + Q) % Q);
    chk("R3 zero minus max", got[0], 1);

    // R4 point-wise product
    run(2, 2, 0, 1, c);
    fetch(2, got);
    for (int i = 0; i < N; i++) chk($sformatf("R4 pmul coef %0d", i), got[i], (pa[i] * pb[i]) % Q);

    // R5 copy and sampler fill
    run(5, 3, 0, 1, c);
    chk("R8 copy cycles", c, N);
    fetch(3, got);
    for (int i = 0; i < N; i++) chk($sformatf("R5 copy coef %0d", i), got[i], pa[i]);
    run(6, 2, 0, 0, c);
    chk("R5 sample cycles", c, N);
    chk("R5 smp_rd low after fill", int'(smp_rd), 0);
    fetch(2, got);
    for (int i = 0; i < N; i++)
      chk($sformatf("R5 sample coef %0d", i), got[i], (smp_f(i) < 0) ? Q + smp_f(i) : smp_f(i));

    // R6 transform round trip
    ident_check(pa, "ramp");
    ident_check(pm, "all max");
    ident_check(pd, "impulse");

    // R7 negacyclic products
    prod_check(pa, pb, "ramp x quad");
    prod_check(px1, pxn, "wrap sign");
    prod_check(pm, pm, "all max");
    prod_check(pz, pb, "zero");

    // R9 command and external write while busy
    load(0, pa);
    load(3, pb);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd0; op_dst = 2'd0; op_src_a = 2'd0; op_src_b = 2'd0;
    @(negedge clk);
    c = busy ? 1 : 0;
    op_code = 3'd3; op_dst = 2'd3; op_src_a = 2'd0; op_src_b = 2'd0;
    ext_we = 1'b1; ext_reg = 2'd3; ext_idx = 4'd0; ext_wdata = 7'((pb[0] + 1) % Q);
    @(negedge clk);
    op_valid = 1'b0;
    ext_we   = 1'b0;
    while (busy) begin
      c++;
      @(negedge clk);
    end
    chk("R9 busy length unchanged", c, NTT_CYC);
    fetch(3, got);
    for (int i = 0; i < N; i++) chk($sformatf("R9 untouched coef %0d", i), got[i], pb[i]);

    // R10 reserved code
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd7; op_dst = 2'd3; op_src_a = 2'd0; op_src_b = 2'd0;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R10 busy stays low", int'(busy), 0);
    @(negedge clk);
    chk("R10 busy still low", int'(busy), 0);
    fetch(3, got);
    for (int i = 0; i < N; i++) chk($sformatf("R10 untouched coef %0d", i), got[i], pb[i]);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule